// File: doc/BRIEF.md
# ALU with Two-Stage Operation Decode

This block is the arithmetic unit of a simple processor datapath together with its own local decoder. The main controller does not pick the ALU operation directly. It sends a coarse two-bit class, and the block turns that class and the six-bit function field of the instruction into a three-bit operation code. The three-bit code then steers a shared adder and a pair of bitwise paths.

A load or store class always adds, which forms a base-plus-offset address. A branch-equal class always subtracts, and the zero flag then tells the controller whether the operands were equal. The arithmetic class reads the function field to choose AND, OR, add, subtract or signed set-on-less-than. The block is purely combinational. It also reports signed overflow on add and subtract so that the controller can raise an exception.

Top module: `alu_twostage`

## Requirements
- R1: Class 00 (memory access) yields operation code 010 and a result of a + b modulo 2^32, whatever the function field holds.
- R2: Class 01 (branch-equal) yields operation code 110 and a result of a − b modulo 2^32, whatever the function field holds.
- R3: With class 10 the function field selects the operation: 100000 selects add (010), 100010 subtract (110), 100100 AND (000), 100101 OR (001), 101010 set-on-less-than (111).
- R4: With class 10, any function value not listed in R3 selects add (010).
- R5: Class 11 decodes exactly as class 10.
- R6: Operation 000 gives a & b, operation 001 gives a | b.
- R7: Set-on-less-than gives 1 in bit 0 and zero in all other bits when a < b as signed two's-complement numbers, and all zeros otherwise. This holds even when a − b overflows.
- R8: The zero output is 1 exactly when all 32 result bits are 0.
- R9: The overflow output is 1 only for add and subtract, and only when the true signed sum or difference falls outside the signed 32-bit range. It is 0 for AND, OR and set-on-less-than.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main controller |
| funct | input | 6 | Function field of the instruction |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| alu_op | output | 3 | Decoded operation code |
| result | output | 32 | ALU result |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow on add or subtract |

## Verification
The bench sweeps all four classes against all 64 function values. A decoder with a swapped or missing table row, or one that treats class 11 differently, produces a wrong operation code there.

Operand pairs are drawn from the signed extremes, ±1, zero and alternating bit patterns, so every operation meets the sign-boundary cases. An unsigned comparison, or a comparison that ignores overflow, gives the wrong set-on-less-than answer for pairs such as the most negative value against 1. An overflow flag that is not gated by the operation shows up on the logic operations. A subtract with the carry-in missing is off by one, which breaks equality in the zero flag.

// File: rtl/alu_twostage.sv
module alu_twostage #(
  parameter int W = 32
) (
  input  logic [1:0]   op_class,
  input  logic [5:0]   funct,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [2:0]   alu_op,
  output logic [W-1:0] result,
  output logic         zero,
  output logic         ovf
);
  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b110;
  localparam logic [2:0] OP_SLT = 3'b111;

  always_comb begin
    case (op_class)
      2'b00:   alu_op = OP_ADD;
      2'b01:   alu_op = OP_SUB;
      default:
        case (funct)
          6'b100010: alu_op = OP_SUB;
          6'b100100: alu_op = OP_AND;
          6'b100101: alu_op = OP_OR;
          6'b101010: alu_op = OP_SLT;
          default:   alu_op = OP_ADD;
        endcase
    endcase
  end

  logic         negb;
  logic [W-1:0] bsel, sum;
  logic         sum_ovf, less;

  assign negb    = alu_op[2];
  assign bsel    = negb ? ~opb : opb;
  assign sum     = opa + bsel + {{(W-1){1'b0}}, negb};
  assign sum_ovf = (opa[W-1] == bsel[W-1]) && (sum[W-1] != opa[W-1]);
  assign less    = sum[W-1] ^ sum_ovf;

  always_comb begin
    case (alu_op[1:0])
      2'b00:   result = opa & opb;
      2'b01:   result = opa | opb;
      2'b10:   result = sum;
      default: result = {{(W-1){1'b0}}, less};
    endcase
  end

  assign zero = (result == '0);
  assign ovf  = sum_ovf && (alu_op == OP_ADD || alu_op == OP_SUB);
endmodule

// File: rtl/alu_twostage_chk.sv
module alu_twostage_chk #(
  parameter int W = 32
) (
  input logic [1:0]   op_class,
  input logic [5:0]   funct,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [2:0]   alu_op,
  input logic [W-1:0] result,
  input logic         zero,
  input logic         ovf
);
  always_comb begin
    // R1
    add_class_chk: assert (op_class != 2'b00 || result == opa + opb);
    // R2
    beq_zero_chk: assert (op_class != 2'b01 || zero == (opa == opb));
    // R7
    slt_upper_chk: assert (alu_op != 3'b111 || result[W-1:1] == '0);
    // R9
    no_overflow_chk: assert (alu_op[1] || !ovf);
    // R5
    class_alias_chk: assert (op_class != 2'b11 || funct != 6'b100100 || result == (opa & opb));
  end
endmodule

bind alu_twostage alu_twostage_chk #(.W(W)) u_chk (.*);

// File: tb/alu_twostage_bench.sv
module alu_twostage_bench;
  logic clk = 0;
  always #10 clk = ~clk;

  logic [1:0]  op_class;
  logic [5:0]  funct;
  logic [31:0] opa, opb, result;
  logic [2:0]  alu_op;
  logic        zero, ovf;
  int checks = 0, errors = 0;
  bit done = 0;

  alu_twostage u_alu_twostage (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_op(logic [1:0] c, logic [5:0] f);
    if (c == 2'b00) return 3'b010;
    if (c == 2'b01) return 3'b110;
    case (f)
      6'b100000: return 3'b010;
      6'b100010: return 3'b110;
      6'b100100: return 3'b000;
      6'b100101: return 3'b001;
      6'b101010: return 3'b111;
      default:   return 3'b010;
    endcase
  endfunction

  task automatic apply(logic [1:0] c, logic [5:0] f, logic [31:0] a, logic [31:0] b);
    @(posedge clk);
    op_class = c; funct = f; opa = a; opb = b;
    @(negedge clk);
  endtask

  task automatic run(logic [1:0] c, logic [5:0] f, logic [31:0] a, logic [31:0] b);
    logic [2:0] op;
    longint sa, sb, full;
    logic [31:0] er;
    logic eo;
    string tag;
    apply(c, f, a, b);
    op = exp_op(c, f);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    eo = 0;
    case (op)
      3'b000: begin er = a & b; tag = "R6 and"; end
      3'b001: begin er = a | b; tag = "R6 or"; end
      3'b110: begin full = sa - sb; er = full[31:0];
                    eo = (full > 64'sd2147483647) || (full < -64'sd2147483648); tag = "R2 sub"; end
      3'b111: begin er = (sa < sb) ? 32'd1 : 32'd0; tag = "R7 slt"; end
      default: begin full = sa + sb; er = full[31:0];
                    eo = (full > 64'sd2147483647) || (full < -64'sd2147483648); tag = "R1 add"; end
    endcase
    chk(tag, result, er);
    chk("R8 zero", {31'd0, zero}, {31'd0, er == 32'd0});
    chk("R9 ovf", {31'd0, ovf}, {31'd0, eo});
  endtask

  logic [31:0] vals [8] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF,
                           32'h80000000, 32'h55555555, 32'hAAAAAAAA, 32'h2};
  logic [5:0] fs [6] = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010, 6'b000111};

  initial begin
    op_class = 0; funct = 0; opa = 0; opb = 0;
    @(negedge clk);
    chk("R8 zero at all-zero inputs", {31'd0, zero}, 32'd1);
    chk("R1 add at all-zero inputs", result, 32'd0);
    for (int c = 0; c < 4; c++)
      for (int f = 0; f < 64; f++) begin
        apply(c[1:0], f[5:0], 32'd7, 32'd3);
        case (c)
          0: chk("R1 opcode", {29'd0, alu_op}, {29'd0, exp_op(c[1:0], f[5:0])});
          1: chk("R2 opcode", {29'd0, alu_op}, {29'd0, exp_op(c[1:0], f[5:0])});
          2: chk("R3 R4 opcode", {29'd0, alu_op}, {29'd0, exp_op(c[1:0], f[5:0])});
          default: chk("R5 opcode", {29'd0, alu_op}, {29'd0, exp_op(c[1:0], f[5:0])});
        endcase
      end
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        run(2'b00, 6'b100101, vals[i], vals[j]);
        run(2'b01, 6'b100100, vals[i], vals[j]);
        for (int k = 0; k < 6; k++) run(2'b10, fs[k], vals[i], vals[j]);
        run(2'b11, 6'b101010, vals[i], vals[j]);
      end
    apply(2'b10, 6'b101010, 32'h80000000, 32'h1);
    chk("R7 slt min vs 1", result, 32'd1);
    apply(2'b10, 6'b101010, 32'h7FFFFFFF, 32'hFFFFFFFF);
    chk("R7 slt max vs -1", result, 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule